// File: doc/BRIEF.md
# Nonlinear Dead-Time Generator

This block turns one reference PWM waveform into a complementary pair of outputs, a high-side drive `oc_o` and a low-side drive `ocn_o`. It puts a programmable guard interval between one output falling and the other rising, so the two are never high together. The output that is turning off goes low on the first clock edge that sees the reference change. The output that is turning on goes high only after a set number of dead-time ticks has been counted.

The guard interval comes from an 8-bit code with a piecewise encoding. Short intervals use a one-tick step. Longer intervals use steps of 2, 8 or 16 ticks, each with a fixed offset. This lets 8 bits reach 1008 ticks. The counter advances only on cycles where `dt_tick_i` is high, so the time base can come from a prescaled strobe.

Top module: `deadtime_gen`

## Requirements
- R1: While `rst_ni` is low, both outputs are low. The first clock edge after reset is released is handled as a reference edge: the output that matches `ref_i` rises after the full dead time.
- R2: When code bit 7 is 0, the dead time equals the code value in ticks (0 to 127).
- R3: When code bits 7:6 are `10`, the dead time is (64 + code[5:0]) × 2 ticks.
- R4: When code bits 7:5 are `110`, the dead time is (32 + code[4:0]) × 8 ticks.
- R5: When code bits 7:5 are `111`, the dead time is (32 + code[4:0]) × 16 ticks.
- R6: On a rising `ref_i`, `ocn_o` is low after the first clock edge that samples the new level. `oc_o` rises at the clock edge that samples the Nth tick after that edge, where N is the dead time.
- R7: On a falling `ref_i`, `oc_o` is low after the first clock edge that samples the new level. `ocn_o` rises at the clock edge that samples the Nth tick after that edge.
- R8: If the reference changes again before the dead time has expired, the output that was waiting never asserts for that pulse. Counting restarts from the new edge.
- R9: A code of 0 passes the reference to `oc_o` and its inverse to `ocn_o`, both updated on the edge-sampling clock edge.
- R10: Clock cycles with `dt_tick_i` low do not advance the dead-time count.
- R11: `oc_o` and `ocn_o` are never high in the same cycle.
- R12: The code is captured on the clock edge that sees the reference edge. Changes to the code during the count have no effect on that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dt_tick_i | input | 1 | Dead-time time-base strobe, one tick per high cycle |
| ref_i | input | 1 | Reference PWM level |
| dt_code_i | input | 8 | Nonlinear dead-time code |
| oc_o | output | 1 | High-side output |
| ocn_o | output | 1 | Low-side (complementary) output |

## Verification
The output that turns off is due one clock edge after the reference changes. With a code of 0, the output that turns on is due on that same edge. Otherwise it is due on the edge that samples the Nth tick, with no earlier edge counted. The bench drives all inputs on falling clock edges and reads the outputs on the next falling edge. It counts the ticks present at each rising edge after the edge-sampling one and compares that count with the value computed from the code formula. A monitor on every falling edge catches any overlap of the two outputs.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned LEN_W  = 10;  // max (32+31)*16 = 1008
  typedef logic [CODE_W-1:0] dt_code_t;
  typedef logic [LEN_W-1:0]  dt_len_t;
endpackage

// File: rtl/dtg_decode.sv
module dtg_decode
  import dtg_pkg::*;
(
  input  dt_code_t code_i,
  output dt_len_t  len_o
);
  always_comb begin
    casez (code_i[7:5])
      3'b0??:  len_o = dt_len_t'(code_i[6:0]);
      3'b10?:  len_o = dt_len_t'({1'b1, code_i[5:0], 1'b0});       // (64+x)*2
      3'b110:  len_o = dt_len_t'({1'b1, code_i[4:0], 3'b000});     // (32+x)*8
      default: len_o = dt_len_t'({1'b1, code_i[4:0], 4'b0000});    // (32+x)*16
    endcase
  end
endmodule

// File: rtl/dtg_chan.sv
module dtg_chan
  import dtg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    ref_i,
  input  dt_len_t len_i,
  output logic    oc_o,
  output logic    ocn_o
);
  logic    ref_q, first_q, oc_q, ocn_q;
  dt_len_t cnt_q;
  logic    edge_w;

  assign edge_w = first_q | (ref_i ^ ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b0;
      first_q <= 1'b1;
      cnt_q   <= '0;
      oc_q    <= 1'b0;
      ocn_q   <= 1'b0;
    end else begin
      first_q <= 1'b0;
      ref_q   <= ref_i;
      if (edge_w) begin
        if (len_i == '0) begin
          oc_q  <= ref_i;
          ocn_q <= ~ref_i;
          cnt_q <= '0;
        end else begin
          oc_q  <= 1'b0;
          ocn_q <= 1'b0;
          cnt_q <= len_i;
        end
      end else if ((cnt_q != '0) && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == dt_len_t'(1)) begin
          oc_q  <= ref_q;
          ocn_q <= ~ref_q;
        end
      end
    end
  end

  assign oc_o  = oc_q;
  assign ocn_o = ocn_q;
endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen
  import dtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dt_tick_i,
  input  logic              ref_i,
  input  logic [CODE_W-1:0] dt_code_i,
  output logic              oc_o,
  output logic              ocn_o
);
  dt_len_t len_w;

  dtg_decode u_dec (
    .code_i (dt_code_i),
    .len_o  (len_w)
  );

  dtg_chan u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (dt_tick_i),
    .ref_i  (ref_i),
    .len_i  (len_w),
    .oc_o   (oc_o),
    .ocn_o  (ocn_o)
  );
endmodule

// File: rtl/deadtime_gen_chk.sv
module deadtime_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_i,
  input logic oc_o,
  input logic ocn_o
);
  // R11
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oc_o && ocn_o));

  // R7
  hi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_i |=> !oc_o);

  // R6
  lo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |=> !ocn_o);

  // R6
  hi_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_o) |-> $past(ref_i));

  // R8
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_o && ref_i) |=> oc_o);
endmodule

bind deadtime_gen deadtime_gen_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ref_i  (ref_i),
  .oc_o   (oc_o),
  .ocn_o  (ocn_o)
);

// File: tb/sim_deadtime_gen.sv
`timescale 1ns/1ps
module sim_deadtime_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dt_tick_i = 1'b0;
  logic       ref_i = 1'b0;
  logic [7:0] dt_code_i = 8'h00;
  logic       oc_o, ocn_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit tick_on = 1'b1;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  deadtime_gen u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dt_tick_i (dt_tick_i),
    .ref_i     (ref_i),
    .dt_code_i (dt_code_i),
    .oc_o      (oc_o),
    .ocn_o     (ocn_o)
  );

  // tick strobe, driven away from the active edge
  always @(negedge clk_i) begin
    if (tick_cnt >= tick_div - 1) tick_cnt = 0;
    else tick_cnt = tick_cnt + 1;
    dt_tick_i = tick_on && (tick_cnt == 0);
  end

  // R11 monitor
  always @(negedge clk_i) begin
    if (rst_ni && oc_o && ocn_o) begin
      errors++;
      $display("FAIL R11 overlap: oc=%0b ocn=%0b expected not both 1", oc_o, ocn_o);
    end
  end

  // {code, expected ticks}: R2 R3 R4 R5 R9
  localparam logic [17:0] VEC [12] = '{
    {8'h00, 10'd0},    {8'h01, 10'd1},    {8'h7F, 10'd127},
    {8'h80, 10'd128},  {8'h85, 10'd138},  {8'hBF, 10'd254},
    {8'hC0, 10'd256},  {8'hC3, 10'd280},  {8'hDF, 10'd504},
    {8'hE0, 10'd512},  {8'hE7, 10'd624},  {8'hFF, 10'd1008}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // after the edge-sampling clock edge: count ticks until the waiting output rises
  task automatic measure(input bit hi_side, output int n, output bit early);
    n = 0;
    early = 1'b0;
    for (int g = 0; g < 40000; g++) begin
      if (hi_side ? oc_o : ocn_o) break;
      @(posedge clk_i);
      if (dt_tick_i) n++;
      @(negedge clk_i);
    end
  endtask

  // drive ref at a negedge, step through edge-sampling posedge, check the drop
  task automatic step_ref(input bit lvl, input string req);
    ref_i = lvl;
    @(posedge clk_i);
    @(negedge clk_i);
    if (lvl) chk(ocn_o == 1'b0, req, ocn_o, 0);
    else     chk(oc_o == 1'b0, req, oc_o, 0);
  endtask

  initial begin
    int n;
    bit e;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(oc_o == 1'b0 && ocn_o == 1'b0, "R1 reset outputs", {oc_o, ocn_o}, 0);
    dt_code_i = 8'h04;
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(ocn_o == 1'b0, "R1 ocn held low after release", ocn_o, 0);
    measure(1'b0, n, e);
    chk(n == 4 && ocn_o, "R1 first dead time", n, 4);

    // table: both directions per code
    tick_div = 2;
    for (int i = 0; i < 12; i++) begin
      dt_code_i = VEC[i][17:10];
      step_ref(1'b1, "R6 low side drop");
      measure(1'b1, n, e);
      chk(n == int'(VEC[i][9:0]) && oc_o, $sformatf("R2-5/R6 rise code %02h", VEC[i][17:10]),
          n, int'(VEC[i][9:0]));
      step_ref(1'b0, "R7 high side drop");
      measure(1'b0, n, e);
      chk(n == int'(VEC[i][9:0]) && ocn_o, $sformatf("R2-5/R7 fall code %02h", VEC[i][17:10]),
          n, int'(VEC[i][9:0]));
    end

    // R9 zero code: rise on the edge-sampling edge
    dt_code_i = 8'h00;
    ref_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(oc_o == 1'b1 && ocn_o == 1'b0, "R9 passthrough rise", {oc_o, ocn_o}, 2);
    ref_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk(oc_o == 1'b0 && ocn_o == 1'b1, "R9 passthrough fall", {oc_o, ocn_o}, 1);

    // R8 short pulse: 16-tick code, pulse of a few ticks
    dt_code_i = 8'h10;
    tick_div = 1;
    begin
      bit seen = 1'b0;
      ref_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(posedge clk_i); @(negedge clk_i);
        if (oc_o) seen = 1'b1;
      end
      step_ref(1'b0, "R8 drop");
      measure(1'b0, n, e);
      chk(!seen && !oc_o, "R8 short pulse oc never high", seen, 0);
      chk(n == 16 && ocn_o, "R8 restart count", n, 16);
    end

    // R10 ticks withheld: no advance
    dt_code_i = 8'h02;
    tick_on = 1'b0;
    step_ref(1'b1, "R10 drop");
    repeat (50) @(negedge clk_i);
    chk(oc_o == 1'b0, "R10 no ticks no rise", oc_o, 0);
    tick_div = 3;
    tick_on = 1'b1;
    measure(1'b1, n, e);
    chk(n == 2 && oc_o, "R10 slow tick count", n, 2);

    // R12 code change mid-count ignored
    tick_div = 1;
    dt_code_i = 8'h20;
    step_ref(1'b0, "R12 drop");
    dt_code_i = 8'h01;
    measure(1'b0, n, e);
    chk(n == 32 && ocn_o, "R12 captured code", n, 32);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule